// File: doc/BRIEF.md
# Class-of-Service Memory Command Arbiter

This block sits in front of a memory controller's command path. Requesters hand it commands over a valid/ready input, each tagged with a connection ID and an address. Up to eight commands are held in a small slot store. Whenever the store is non-empty, one command is offered on a valid/ready issue port. At most one command leaves per cycle.

A configuration port selects one connection ID as the high-priority class. Commands from that ID are chosen ahead of default-class traffic. Each class has a programmable wait limit. A command that has sat in the store for its class limit plus one cycles becomes "expired" and is issued ahead of every unexpired command. This caps the latency of any command. A low limit favours latency, and a high limit gives the other class more room.

A command's class is fixed when the command is accepted. It is taken from the mapping in force in that cycle.

Top module: `cos_cmd_arbiter`

## Requirements
- R1: `in_ready` is low exactly when all 8 slots are occupied. While it is low, an asserted `in_valid` is ignored and no command is stored.
- R2: `out_valid` is high whenever at least one command is stored. A command leaves the store only in a cycle with `out_valid` and `out_ready` both high. At most one command leaves per cycle.
- R3: When the mapping enable is clear, all commands are default class. If none has expired, they issue in arrival order, even if a command's ID equals the programmed ID.
- R4: When the mapping enable is set, a command whose connection ID equals the programmed ID is high class. Among unexpired commands, a high-class command is issued before any default-class command.
- R5: Among several high-class commands, the earliest accepted issues first. The same holds among several default-class commands.
- R6: A command accepted at clock edge E has an age of n during the cycle after edge E+n. It is expired once its age is at least its class limit, which means it has been held for limit+1 cycles. An expired command outranks every unexpired command of either class. Select 1 writes the default-class limit and select 2 writes the high-class limit, each from `cfg_wdata[CNT_W-1:0]`.
- R7: When several commands are expired, the earliest accepted one issues first, whatever its class.
- R8: A configuration write with select 0 loads the connection ID from `cfg_wdata[ID_W-1:0]` and the enable from `cfg_wdata[ID_W]`. A write with select 3 changes nothing. Reset leaves the enable clear, the ID at 0 and both limits at `RST_CNT` (15).
- R9: After reset the store is empty: `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | A slot is free |
| in_conn_id | input | ID_W | Connection ID of offered command |
| in_addr | input | ADDR_W | Address of offered command |
| out_valid | output | 1 | A command is offered for issue |
| out_ready | input | 1 | Downstream takes the command |
| out_conn_id | output | ID_W | Connection ID of issued command |
| out_addr | output | ADDR_W | Address of issued command |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select (0 map, 1 default limit, 2 high limit) |
| cfg_wdata | input | CFG_W | Configuration write data |

## Verification
The bench fills the store completely and offers one more command. A design that accepted it would later issue an extra command, or would lose an earlier one. The bench interleaves high-class and default-class commands, which catches a picker that falls back to arrival order or reverses order within a class. It ages a default-class command past its limit while a younger high-class command waits. A design with the limit comparison off by one cycle would switch to the expired command one cycle early or one cycle late. With a zero limit, the bench expires two default-class commands behind an older high-class one. A design that ranked class above expiry, or that did not order the expired commands by age, would issue them in the wrong sequence.

// File: rtl/cos_arb_pkg.sv
package cos_arb_pkg;

   // configuration field select codes
   typedef enum logic [1:0] {
      SEL_MAP    = 2'd0,
      SEL_LIM_LO = 2'd1,
      SEL_LIM_HI = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

   // command class
   typedef enum logic {
      CLS_DEF = 1'b0,
      CLS_HI  = 1'b1
   } cls_e;

endpackage

// File: rtl/cos_arb_cfg.sv
module cos_arb_cfg
   import cos_arb_pkg::*;
#(
   parameter int unsigned ID_W    = 8,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned RST_CNT = 15,
   parameter int unsigned CFG_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       sel,
   input  logic [CFG_W-1:0] wdata,
   output logic [ID_W-1:0]  map_id,
   output logic             map_en,
   output logic [CNT_W-1:0] lim_lo,
   output logic [CNT_W-1:0] lim_hi
);

   if (CFG_W < ID_W + 1 || CFG_W < CNT_W) begin : g_bad_cfg_w
      $error("cos_arb_cfg: CFG_W too narrow for ID or limit field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_id <= '0;
         map_en <= 1'b0;
         lim_lo <= CNT_W'(RST_CNT);
         lim_hi <= CNT_W'(RST_CNT);
      end else if (we) begin
         case (cfg_sel_e'(sel))
            SEL_MAP: begin
               map_id <= wdata[ID_W-1:0];
               map_en <= wdata[ID_W];
            end
            SEL_LIM_LO: lim_lo <= wdata[CNT_W-1:0];
            SEL_LIM_HI: lim_hi <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cos_arb_slots.sv
module cos_arb_slots #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ID_W   = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               push,
   input  logic [ID_W-1:0]                    push_id,
   input  logic [ADDR_W-1:0]                  push_addr,
   input  logic                               push_hi,
   input  logic                               pop,
   input  logic [DEPTH-1:0]                   pop_oh,
   output logic [DEPTH-1:0]                   valid,
   output logic [DEPTH-1:0][ID_W-1:0]         ids,
   output logic [DEPTH-1:0][ADDR_W-1:0]       addrs,
   output logic [DEPTH-1:0]                   hi,
   output logic [DEPTH-1:0][CNT_W-1:0]        ages,
   output logic [DEPTH-1:0][DEPTH-1:0]        older,
   output logic                               full
);

   logic [DEPTH-1:0] ins_oh;

   // lowest free slot receives the next command
   always_comb begin
      ins_oh = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            ins_oh    = '0;
            ins_oh[i] = 1'b1;
         end
      end
   end

   assign full = &valid;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic              v_q;
      logic              hi_q;
      logic [ID_W-1:0]   id_q;
      logic [ADDR_W-1:0] addr_q;
      logic [CNT_W-1:0]  age_q;
      logic [DEPTH-1:0]  row_q;   // row_q[j]: this slot arrived before slot j

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            hi_q   <= 1'b0;
            id_q   <= '0;
            addr_q <= '0;
            age_q  <= '0;
            row_q  <= '0;
         end else if (push && ins_oh[gi]) begin
            v_q    <= 1'b1;
            hi_q   <= push_hi;
            id_q   <= push_id;
            addr_q <= push_addr;
            age_q  <= '0;
            row_q  <= '0;
         end else begin
            if (pop && pop_oh[gi])
               v_q <= 1'b0;
            else if (v_q && age_q != '1)
               age_q <= age_q + 1'b1;
            if (push)
               row_q <= (row_q & ~ins_oh) | (v_q ? ins_oh : '0);
         end
      end

      assign valid[gi] = v_q;
      assign hi[gi]    = hi_q;
      assign ids[gi]   = id_q;
      assign addrs[gi] = addr_q;
      assign ages[gi]  = age_q;
      assign older[gi] = row_q;
   end

endmodule

// File: rtl/cos_arb_pick.sv
module cos_arb_pick #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic [DEPTH-1:0]            valid,
   input  logic [DEPTH-1:0]            hi,
   input  logic [DEPTH-1:0][CNT_W-1:0] ages,
   input  logic [DEPTH-1:0][DEPTH-1:0] older,
   input  logic [CNT_W-1:0]            lim_lo,
   input  logic [CNT_W-1:0]            lim_hi,
   output logic [DEPTH-1:0]            grant
);

   logic [DEPTH-1:0] expired;
   logic [DEPTH-1:0] hi_v;
   logic [DEPTH-1:0] cand;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         expired[i] = valid[i] && (ages[i] >= (hi[i] ? lim_hi : lim_lo));
         hi_v[i]    = valid[i] && hi[i];
      end
      // tier order: expired, then high class, then everything
      if (|expired)   cand = expired;
      else if (|hi_v) cand = hi_v;
      else            cand = valid;
   end

   // within the chosen tier, the candidate no other candidate predates wins
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_age
      logic [DEPTH-1:0] beaten_by;
      always_comb begin
         for (int j = 0; j < DEPTH; j++)
            beaten_by[j] = cand[j] && older[j][gi];
      end
      assign grant[gi] = cand[gi] && !(|beaten_by);
   end

endmodule

// File: rtl/cos_cmd_arbiter.sv
module cos_cmd_arbiter
   import cos_arb_pkg::*;
#(
   parameter  int unsigned DEPTH   = 8,
   parameter  int unsigned ID_W    = 8,
   parameter  int unsigned ADDR_W  = 32,
   parameter  int unsigned CNT_W   = 8,
   parameter  int unsigned RST_CNT = 15,
   localparam int unsigned CFG_W   = (ID_W + 1 > CNT_W) ? ID_W + 1 : CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ID_W-1:0]   in_conn_id,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ID_W-1:0]   out_conn_id,
   output logic [ADDR_W-1:0] out_addr,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cos_cmd_arbiter: DEPTH must be at least 2");
   end
   if (ID_W < 1 || ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("cos_cmd_arbiter: widths must be nonzero");
   end
   if (CNT_W < 32 && RST_CNT >= (1 << CNT_W)) begin : g_bad_rst
      $error("cos_cmd_arbiter: RST_CNT does not fit CNT_W");
   end

   logic [ID_W-1:0]             map_id;
   logic                        map_en;
   logic [CNT_W-1:0]            lim_lo;
   logic [CNT_W-1:0]            lim_hi;
   logic [DEPTH-1:0]            slot_v;
   logic [DEPTH-1:0][ID_W-1:0]  slot_id;
   logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
   logic [DEPTH-1:0]            slot_hi;
   logic [DEPTH-1:0][CNT_W-1:0] slot_age;
   logic [DEPTH-1:0][DEPTH-1:0] slot_older;
   logic [DEPTH-1:0]            grant_w;
   logic                        full;
   logic                        accept;
   logic                        issue;
   cls_e                        in_cls;

   cos_arb_cfg #(
      .ID_W(ID_W), .CNT_W(CNT_W), .RST_CNT(RST_CNT), .CFG_W(CFG_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .map_id(map_id), .map_en(map_en), .lim_lo(lim_lo), .lim_hi(lim_hi)
   );

   assign in_ready = !full;
   assign accept   = in_valid && in_ready;
   assign in_cls   = (map_en && in_conn_id == map_id) ? CLS_HI : CLS_DEF;

   cos_arb_slots #(
      .DEPTH(DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) slots_i (
      .clk(clk), .rst_n(rst_n),
      .push(accept), .push_id(in_conn_id), .push_addr(in_addr),
      .push_hi(in_cls == CLS_HI),
      .pop(issue), .pop_oh(grant_w),
      .valid(slot_v), .ids(slot_id), .addrs(slot_addr), .hi(slot_hi),
      .ages(slot_age), .older(slot_older), .full(full)
   );

   cos_arb_pick #(
      .DEPTH(DEPTH), .CNT_W(CNT_W)
   ) pick_i (
      .valid(slot_v), .hi(slot_hi), .ages(slot_age), .older(slot_older),
      .lim_lo(lim_lo), .lim_hi(lim_hi), .grant(grant_w)
   );

   assign out_valid = |slot_v;
   assign issue     = out_valid && out_ready;

   always_comb begin
      out_conn_id = '0;
      out_addr    = '0;
      for (int i = 0; i < DEPTH; i++) begin
         out_conn_id = out_conn_id | (slot_id[i] & {ID_W{grant_w[i]}});
         out_addr    = out_addr | (slot_addr[i] & {ADDR_W{grant_w[i]}});
      end
   end

endmodule

// File: rtl/cos_cmd_arbiter_chk.sv
module cos_cmd_arbiter_chk #(
   parameter int unsigned DEPTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [DEPTH-1:0] grant
);

   localparam int unsigned OCC_W = $clog2(DEPTH + 1);
   localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

   logic [OCC_W-1:0] occ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         occ_q <= '0;
      else
         occ_q <= occ_q + OCC_W'(in_valid && in_ready) - OCC_W'(out_valid && out_ready);
   end

   // R1
   ready_tracks_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (occ_q < OCC_MAX));

   // R2
   valid_tracks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (occ_q != '0));

   // R2
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R2
   grant_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(grant) == 1);

endmodule

bind cos_cmd_arbiter cos_cmd_arbiter_chk #(.DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .grant(grant_w)
);

// File: tb/cos_cmd_arbiter_tb_top.sv
module cos_cmd_arbiter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ID_W   = 8;
   localparam int ADDR_W = 32;
   localparam int CFG_W  = 9;
   localparam logic [ID_W-1:0] HI_ID = 8'h25;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [ID_W-1:0]   in_conn_id = '0;
   logic [ADDR_W-1:0] in_addr = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [ID_W-1:0]   out_conn_id;
   logic [ADDR_W-1:0] out_addr;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [CFG_W-1:0]  cfg_wdata = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cos_cmd_arbiter dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_conn_id(in_conn_id), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_conn_id(out_conn_id), .out_addr(out_addr),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic cfg_write(input logic [1:0] sel, input logic [CFG_W-1:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr);
      in_valid = 1'b1; in_conn_id = id; in_addr = addr;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pop_expect(input string req, input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr);
      check(req, "out_valid", longint'(out_valid), 1);
      check(req, "out_conn_id", longint'(out_conn_id), longint'(id));
      check(req, "out_addr", longint'(out_addr), longint'(addr));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic t_reset;
      check("R9", "out_valid after reset", longint'(out_valid), 0);
      check("R9", "in_ready after reset", longint'(in_ready), 1);
   endtask

   task automatic t_reset_defaults;
      // R8: mapping disabled at reset, so ID 0 gets no priority
      push(8'h05, 32'h10);
      push(8'h00, 32'h20);
      pop_expect("R8", 8'h05, 32'h10);
      pop_expect("R8", 8'h00, 32'h20);
   endtask

   task automatic t_full_and_order;
      cfg_write(2'd1, 9'd255);
      cfg_write(2'd2, 9'd255);
      for (int k = 0; k < 8; k++) push(ID_W'(8'h10 + k), ADDR_W'(k * 4));
      check("R1", "in_ready when full", longint'(in_ready), 0);
      push(8'h99, 32'hDEAD);
      check("R1", "in_ready after refused push", longint'(in_ready), 0);
      // R3: arrival order with mapping off
      for (int k = 0; k < 8; k++) pop_expect("R3", ID_W'(8'h10 + k), ADDR_W'(k * 4));
      check("R1", "refused command absent", longint'(out_valid), 0);
      check("R2", "in_ready after drain", longint'(in_ready), 1);
      // R3: matching ID with enable clear stays default class
      cfg_write(2'd0, {1'b0, HI_ID});
      push(8'h01, 32'h30);
      push(HI_ID, 32'h31);
      pop_expect("R3", 8'h01, 32'h30);
      pop_expect("R3", HI_ID, 32'h31);
   endtask

   task automatic t_high_class;
      cfg_write(2'd0, {1'b1, HI_ID});
      push(8'h01, 32'h100);
      push(HI_ID, 32'h200);
      push(8'h02, 32'h300);
      push(HI_ID, 32'h400);
      pop_expect("R4", HI_ID, 32'h200);
      pop_expect("R5", HI_ID, 32'h400);
      pop_expect("R5", 8'h01, 32'h100);
      pop_expect("R5", 8'h02, 32'h300);
      check("R2", "empty after drain", longint'(out_valid), 0);
   endtask

   task automatic t_expire;
      cfg_write(2'd1, 9'd5);
      cfg_write(2'd2, 9'd255);
      push(8'h01, 32'hA0);
      push(HI_ID, 32'hB0);
      check("R4", "high class first, age 1", longint'(out_conn_id), longint'(HI_ID));
      repeat (3) @(negedge clk);
      check("R6", "not expired at age 4", longint'(out_conn_id), longint'(HI_ID));
      @(negedge clk);
      pop_expect("R6", 8'h01, 32'hA0);
      pop_expect("R6", HI_ID, 32'hB0);
   endtask

   task automatic t_expired_order;
      cfg_write(2'd1, 9'd0);
      push(HI_ID, 32'hC0);
      push(8'h02, 32'hC1);
      push(8'h03, 32'hC2);
      pop_expect("R7", 8'h02, 32'hC1);
      pop_expect("R7", 8'h03, 32'hC2);
      pop_expect("R7", HI_ID, 32'hC0);
   endtask

   task automatic t_reserved_sel;
      cfg_write(2'd1, 9'd255);
      cfg_write(2'd3, 9'd0);
      push(8'h01, 32'hE0);
      push(HI_ID, 32'hE1);
      pop_expect("R8", HI_ID, 32'hE1);
      pop_expect("R8", 8'h01, 32'hE0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reset_defaults();
      t_full_and_order();
      t_high_class();
      t_expire();
      t_expired_order();
      t_reserved_sel();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule